// File: doc/BRIEF.md
# LPC I/O Burst Host

This block is a register-programmed host that runs one-byte I/O read or write cycles on a Low Pin Count bus. Software programs a cycle count, a mode word and a 16-bit target port. It pushes write bytes into a byte FIFO, then starts the engine. The block runs a burst of up to 16 back-to-back bus cycles. Each cycle either hits the same port, which suits stream devices, or steps the port up by one.

Software polls a status word. When the idle bit is set, a separate success bit tells a clean finish from an aborted burst. Bytes read from the bus land in a second byte FIFO in cycle order, and software pops them one register read at a time. A sticky done event bit, cleared by writing a one to it, marks the end of every burst.

The bus side drives a 4-bit multiplexed address/data nibble bus with an output enable and an active-low frame strobe. It samples the nibble bus from a single peripheral. The bus clock is the block clock.

Top module: `lpc_io_host`

## Requirements
- R1: After reset the status word (offset 0x04) reads 1, meaning idle set and success clear. The event word (offset 0x08) reads 0. lframe_no is 1 and lad_oe_o is 0.
- R2: Writing a value with bit 0 set to offset 0x00 starts a burst, but only when the count register (offset 0x10, bits 7:0) holds a value from 1 to 16. With a count of 0 or above 16, the start is ignored and the bus stays quiet.
- R3: Each cycle drives the following nibbles, one clock each with the output enable on:
  - the start nibble 0000, with lframe_no low for that clock only;
  - a type nibble, 0010 for a write or 0000 for a read;
  - the four port nibbles, high nibble first;
  - for a write only, the data byte, low nibble first;
  - a 1111 turnaround clock.
  The host then releases the bus for one turnaround clock and samples SYNC.
- R4: In a read cycle, after a ready SYNC the host samples two data nibbles (low first) and then two turnaround clocks. Each byte is queued in cycle order and popped by reads of offset 0x28. A pop of an empty queue reads 0.
- R5: Mode register (offset 0x14) bit 0 set selects write and clear selects read. Bit 3 set keeps the port fixed for the whole burst. Bit 3 clear adds one to the 16-bit port after each cycle, wrapping at 0xFFFF.
- R6: SYNC 0000 means ready. SYNC 0101 or 0110 is a wait, and up to 256 wait clocks per cycle are accepted. A 257th wait clock aborts the burst.
- R7: SYNC 1010 aborts the burst. Three non-ready, non-wait, non-error SYNC nibbles within one cycle also abort it. An abort runs no further cycles and ends idle with success clear.
- R8: Status bit 0 is idle and bit 1 is success. Success is cleared by a start and set only when every cycle of the burst completed.
- R9: Event bit 1 sets when any burst ends. Writing a 1 to bit 1 of offset 0x08 clears it, and writing 0 there leaves it set.
- R10: While a burst runs, writes to the count, mode, port (offset 0x20) and write-data (offset 0x24) registers are ignored, and so is a start.
- R11: The write FIFO holds 16 bytes, and pushes while full are dropped. It is emptied when a burst ends, whether it finished or aborted. A write cycle that finds it empty sends 0x00. A start empties the read FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block and bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the read FIFO at offset 0x28) |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on reg_addr_i |
| lframe_no | output | 1 | Frame strobe, active low |
| lad_o | output | 4 | Nibble bus out |
| lad_oe_o | output | 1 | Nibble bus output enable |
| lad_i | input | 4 | Nibble bus in |

## Verification
A start written at one clock edge puts the start nibble on the bus in the very next cycle. Every later nibble follows one clock apart, so the bench lays out the whole expected bus trace before the start and compares each entry half a clock after the edge that produced it. The bench drives peripheral nibbles at the same half-clock point, so the sequencer samples them on the following edge. The edge that ends a burst also updates idle, success, the event bit and the FIFO flush, so status checks run one cycle after the last trace entry. Register reads see combinational data, and the read-FIFO pop lands on the next edge.

// File: rtl/lpc_io_host_pkg.sv
package lpc_io_host_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CTDIR, S_ADDR, S_WDAT, S_TAR1, S_SYNC, S_RDAT, S_TAR2
  } seq_st_e;

  localparam logic [5:0] OFS_GO    = 6'h00;
  localparam logic [5:0] OFS_STAT  = 6'h04;
  localparam logic [5:0] OFS_EVT   = 6'h08;
  localparam logic [5:0] OFS_CNT   = 6'h10;
  localparam logic [5:0] OFS_MODE  = 6'h14;
  localparam logic [5:0] OFS_PORT  = 6'h20;
  localparam logic [5:0] OFS_WBYTE = 6'h24;
  localparam logic [5:0] OFS_RBYTE = 6'h28;

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [3:0] NIB_CT_RD = 4'b0000;
  localparam logic [3:0] NIB_CT_WR = 4'b0010;
  localparam logic [3:0] SYNC_RDY  = 4'b0000;
  localparam logic [3:0] SYNC_SWT  = 4'b0101;
  localparam logic [3:0] SYNC_LWT  = 4'b0110;
  localparam logic [3:0] SYNC_ERR  = 4'b1010;
endpackage

// File: rtl/lpc_byte_fifo.sv
module lpc_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic                       pop_i,
  output logic [W-1:0]               dout_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH):0]     cnt_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp_q, wp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q != (AW+1)'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q <= '0; wp_q <= '0; cnt_q <= '0;
    end else if (clr_i) begin
      rp_q <= '0; wp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wp_q] <= din_i;
  end

  assign dout_o  = mem[rp_q];
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/lpc_burst_seq.sv
module lpc_burst_seq
  import lpc_io_host_pkg::*;
#(
  parameter int MAX_LEN    = 16,
  parameter int MAX_WAIT   = 256,
  parameter int NOSYNC_LIM = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         go_i,
  input  logic [$clog2(MAX_LEN+1)-1:0] len_i,
  input  logic                         wr_i,
  input  logic                         same_i,
  input  logic [15:0]                  port_i,
  input  logic [7:0]                   wbyte_i,
  output logic                         wpop_o,
  output logic                         rpush_o,
  output logic [7:0]                   rbyte_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         ok_o,
  output logic                         lframe_no,
  output logic [3:0]                   lad_o,
  output logic                         lad_oe_o,
  input  logic [3:0]                   lad_i
);
  localparam int LW = $clog2(MAX_LEN+1);
  localparam int WW = $clog2(MAX_WAIT+1);
  localparam int NW = $clog2(NOSYNC_LIM+1);

  seq_st_e     st_q;
  logic [1:0]  nib_q;
  logic [LW-1:0] idx_q, len_q;
  logic        wr_q, same_q;
  logic [15:0] addr_q;
  logic [7:0]  wbuf_q;
  logic [3:0]  rlo_q;
  logic [WW-1:0] wait_q;
  logic [NW-1:0] bad_q;
  logic        is_wait, is_bad, fail_c, fin_c;

  assign is_wait = (lad_i == SYNC_SWT) || (lad_i == SYNC_LWT);
  assign is_bad  = !is_wait && (lad_i != SYNC_RDY) && (lad_i != SYNC_ERR);
  assign fail_c  = (st_q == S_SYNC) &&
                   ((lad_i == SYNC_ERR) ||
                    (is_wait && wait_q == WW'(MAX_WAIT)) ||
                    (is_bad && bad_q == NW'(NOSYNC_LIM-1)));
  assign fin_c   = (st_q == S_TAR2) && nib_q[0] && (idx_q == len_q - LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; nib_q <= '0; idx_q <= '0; len_q <= '0;
      wr_q <= 1'b0; same_q <= 1'b0; addr_q <= '0; wbuf_q <= '0;
      rlo_q <= '0; wait_q <= '0; bad_q <= '0;
    end else if (fail_c) begin
      st_q <= S_IDLE;
    end else begin
      case (st_q)
        S_IDLE: if (go_i) begin
          len_q <= len_i; wr_q <= wr_i; same_q <= same_i;
          addr_q <= port_i; idx_q <= '0; nib_q <= '0; st_q <= S_START;
        end
        S_START: begin
          wbuf_q <= wr_q ? wbyte_i : 8'h00;
          st_q <= S_CTDIR;
        end
        S_CTDIR: begin nib_q <= '0; st_q <= S_ADDR; end
        S_ADDR: begin
          nib_q <= nib_q + 1'b1;
          if (nib_q == 2'd3) begin nib_q <= '0; st_q <= wr_q ? S_WDAT : S_TAR1; end
        end
        S_WDAT: begin
          nib_q <= nib_q + 1'b1;
          if (nib_q[0]) begin nib_q <= '0; st_q <= S_TAR1; end
        end
        S_TAR1: begin
          wait_q <= '0; bad_q <= '0; nib_q <= nib_q + 1'b1;
          if (nib_q[0]) begin nib_q <= '0; st_q <= S_SYNC; end
        end
        S_SYNC: begin
          if (lad_i == SYNC_RDY) st_q <= wr_q ? S_TAR2 : S_RDAT;
          else if (is_wait)      wait_q <= wait_q + 1'b1;
          else                   bad_q <= bad_q + 1'b1;
        end
        S_RDAT: begin
          nib_q <= nib_q + 1'b1;
          if (!nib_q[0]) rlo_q <= lad_i;
          else begin nib_q <= '0; st_q <= S_TAR2; end
        end
        S_TAR2: begin
          nib_q <= nib_q + 1'b1;
          if (nib_q[0]) begin
            nib_q <= '0;
            if (fin_c) st_q <= S_IDLE;
            else begin
              idx_q <= idx_q + 1'b1;
              if (!same_q) addr_q <= addr_q + 16'd1;
              st_q <= S_START;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    lad_oe_o = 1'b1;
    lad_o    = 4'hf;
    case (st_q)
      S_START: lad_o = NIB_START;
      S_CTDIR: lad_o = wr_q ? NIB_CT_WR : NIB_CT_RD;
      S_ADDR:  lad_o = addr_q[{~nib_q, 2'b00} +: 4];
      S_WDAT:  lad_o = nib_q[0] ? wbuf_q[7:4] : wbuf_q[3:0];
      S_TAR1:  lad_oe_o = !nib_q[0];
      default: lad_oe_o = 1'b0;
    endcase
  end

  assign lframe_no = (st_q != S_START);
  assign wpop_o    = (st_q == S_START) && wr_q;
  assign rpush_o   = (st_q == S_RDAT) && nib_q[0];
  assign rbyte_o   = {lad_i, rlo_q};
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = fin_c || fail_c;
  assign ok_o      = fin_c;
endmodule

// File: rtl/lpc_io_host.sv
module lpc_io_host
  import lpc_io_host_pkg::*;
#(
  parameter int MAX_LEN    = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_WAIT   = 256,
  parameter int NOSYNC_LIM = 3,
  parameter int DW         = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [5:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          lframe_no,
  output logic [3:0]    lad_o,
  output logic          lad_oe_o,
  input  logic [3:0]    lad_i
);
  localparam int LW = $clog2(MAX_LEN+1);
  localparam int FW = $clog2(FIFO_DEPTH)+1;

  logic [7:0]  cnt_q;
  logic        wr_q, same_q, ok_q, evt_q;
  logic [15:0] port_q;
  logic        seq_busy, seq_done, seq_ok, wpop, rpush;
  logic [7:0]  rbyte, wf_dout, rf_dout;
  logic        wf_empty, rf_empty;
  logic [FW-1:0] wf_cnt, rf_cnt;
  logic        cfg_we, go, cnt_ok;

  assign cfg_we = reg_we_i && !seq_busy;
  assign cnt_ok = (cnt_q != 8'd0) && (cnt_q <= 8'(MAX_LEN));
  assign go     = cfg_we && (reg_addr_i == OFS_GO) && reg_wdata_i[0] && cnt_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; wr_q <= 1'b0; same_q <= 1'b0; port_q <= '0;
      ok_q <= 1'b0; evt_q <= 1'b0;
    end else begin
      if (cfg_we && reg_addr_i == OFS_CNT)  cnt_q  <= reg_wdata_i[7:0];
      if (cfg_we && reg_addr_i == OFS_MODE) begin
        wr_q <= reg_wdata_i[0]; same_q <= reg_wdata_i[3];
      end
      if (cfg_we && reg_addr_i == OFS_PORT) port_q <= reg_wdata_i[15:0];
      if (go) ok_q <= 1'b0;
      else if (seq_done) ok_q <= seq_ok;
      if (seq_done) evt_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == OFS_EVT && reg_wdata_i[1]) evt_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_STAT:  reg_rdata_o = DW'({ok_q, !seq_busy});
      OFS_EVT:   reg_rdata_o = DW'({evt_q, 1'b0});
      OFS_CNT:   reg_rdata_o = DW'(cnt_q);
      OFS_MODE:  reg_rdata_o = DW'({same_q, 2'b00, wr_q});
      OFS_PORT:  reg_rdata_o = DW'(port_q);
      OFS_RBYTE: reg_rdata_o = rf_empty ? '0 : DW'(rf_dout);
      default:   reg_rdata_o = '0;
    endcase
  end

  lpc_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_wfifo (
    .clk_i, .rst_ni, .clr_i(seq_done),
    .push_i(cfg_we && reg_addr_i == OFS_WBYTE), .din_i(reg_wdata_i[7:0]),
    .pop_i(wpop), .dout_o(wf_dout), .empty_o(wf_empty), .cnt_o(wf_cnt)
  );

  lpc_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rfifo (
    .clk_i, .rst_ni, .clr_i(go),
    .push_i(rpush), .din_i(rbyte),
    .pop_i(reg_re_i && reg_addr_i == OFS_RBYTE),
    .dout_o(rf_dout), .empty_o(rf_empty), .cnt_o(rf_cnt)
  );

  lpc_burst_seq #(.MAX_LEN(MAX_LEN), .MAX_WAIT(MAX_WAIT), .NOSYNC_LIM(NOSYNC_LIM)) u_seq (
    .clk_i, .rst_ni, .go_i(go), .len_i(cnt_q[LW-1:0]),
    .wr_i(wr_q), .same_i(same_q), .port_i(port_q),
    .wbyte_i(wf_empty ? 8'h00 : wf_dout), .wpop_o(wpop),
    .rpush_o(rpush), .rbyte_o(rbyte), .busy_o(seq_busy),
    .done_o(seq_done), .ok_o(seq_ok),
    .lframe_no, .lad_o, .lad_oe_o, .lad_i
  );
endmodule

// File: rtl/lpc_io_host_chk.sv
module lpc_io_host_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lframe_no,
  input logic          lad_oe_o,
  input logic [3:0]    lad_o,
  input logic          busy,
  input logic          done,
  input logic          ok_q,
  input logic          evt_q,
  input logic [15:0]   port_q,
  input logic [CW-1:0] wf_cnt,
  input logic [CW-1:0] rf_cnt
);
  a_r3_frame_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_no |=> lframe_no);
  a_r3_frame_drives_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_no |-> (lad_oe_o && lad_o == 4'b0000));
  a_r1_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (lframe_no && !lad_oe_o));
  a_r8_ok_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |-> !busy);
  a_r9_done_sets_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> evt_q);
  a_r10_port_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(port_q));
  a_r11_fifo_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wf_cnt <= CW'(DEPTH)) && (rf_cnt <= CW'(DEPTH)));
  a_r11_wfifo_flushed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (wf_cnt == '0));
endmodule

bind lpc_io_host lpc_io_host_chk #(.DEPTH(FIFO_DEPTH), .CW($clog2(FIFO_DEPTH)+1)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lframe_no(lframe_no), .lad_oe_o(lad_oe_o),
  .lad_o(lad_o), .busy(seq_busy), .done(seq_done), .ok_q(ok_q), .evt_q(evt_q),
  .port_q(port_q), .wf_cnt(wf_cnt), .rf_cnt(rf_cnt)
);

// File: tb/lpc_io_host_tb.sv
`timescale 1ns/1ps
module lpc_io_host_tb;
  typedef struct packed {
    logic       fr;
    logic       oe;
    logic [3:0] lo;
    logic [3:0] di;
  } ent_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        lframe_n, lad_oe;
  logic [3:0]  lad_out;
  logic [3:0]  lad_in = 4'hf;

  int   n_cmp = 0, n_bad = 0;
  ent_t trace[$];
  bit   armed = 1'b0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  lpc_io_host u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .lframe_no(lframe_n), .lad_o(lad_out), .lad_oe_o(lad_oe), .lad_i(lad_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bus model: compares every clock, drives peripheral nibbles.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (armed && trace.size() != 0) begin
        ent_t e;
        e = trace.pop_front();
        chk("R3 frame", {31'd0, lframe_n}, {31'd0, e.fr});
        chk("R3 oe", {31'd0, lad_oe}, {31'd0, e.oe});
        if (e.oe) chk("R3/R5 nibble", {28'd0, lad_out}, {28'd0, e.lo});
        lad_in = e.di;
        if (trace.size() == 0) armed = 1'b0;
      end else begin
        chk("R2 bus quiet", {30'd0, lframe_n, lad_oe}, 32'd2);
        lad_in = 4'hf;
      end
    end
  end

  task automatic pe(input logic fr, input logic oe, input logic [3:0] lo, input logic [3:0] di);
    ent_t e;
    e.fr = fr; e.oe = oe; e.lo = lo; e.di = di;
    trace.push_back(e);
  endtask

  // One bus cycle; fin = final SYNC nibble (0 ready, else abort)
  task automatic add_cyc(input bit wr, input logic [15:0] a, input logic [7:0] d,
                         input int waits, input int bad, input logic [3:0] fin);
    pe(0, 1, 4'h0, 4'hf);
    pe(1, 1, wr ? 4'h2 : 4'h0, 4'hf);
    for (int i = 3; i >= 0; i--) pe(1, 1, a[4*i +: 4], 4'hf);
    if (wr) begin pe(1, 1, d[3:0], 4'hf); pe(1, 1, d[7:4], 4'hf); end
    pe(1, 1, 4'hf, 4'hf);
    pe(1, 0, 4'h0, 4'hf);
    for (int i = 0; i < bad; i++) pe(1, 0, 4'h0, 4'hf);
    for (int i = 0; i < waits; i++) pe(1, 0, 4'h0, (i % 2) ? 4'h5 : 4'h6);
    pe(1, 0, 4'h0, fin);
    if (fin == 4'h0) begin
      if (!wr) begin pe(1, 0, 4'h0, d[3:0]); pe(1, 0, 4'h0, d[7:4]); end
      pe(1, 0, 4'h0, 4'hf); pe(1, 0, 4'h0, 4'hf);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [15:0] d);
    addr = a; re = 1'b1;
    #2 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic go_wait();
    wr_reg(6'h00, 16'h1);
    armed = 1'b1;
    wait (armed == 1'b0);
    @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] cnt, input logic [15:0] mode, input logic [15:0] port);
    wr_reg(6'h10, {8'h00, cnt});
    wr_reg(6'h14, mode);
    wr_reg(6'h20, port);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 frame", {31'd0, lframe_n}, 32'd1);
    chk("R1 oe", {31'd0, lad_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(6'h04, rv); chk("R1 stat", rv, 32'h1);
    rd_reg(6'h08, rv); chk("R1 evt", rv, 32'h0);

    // R2: bad counts ignored
    wr_reg(6'h10, 16'h0); wr_reg(6'h00, 16'h1);
    repeat (3) @(negedge clk);
    rd_reg(6'h04, rv); chk("R2 cnt0 idle", rv, 32'h1);
    wr_reg(6'h10, 16'd17); wr_reg(6'h00, 16'h1);
    repeat (3) @(negedge clk);
    rd_reg(6'h08, rv); chk("R2 cnt17 no event", rv, 32'h0);

    // R3/R5: write burst, incrementing port with carry
    setup(8'd3, 16'h1, 16'h12FE);
    wr_reg(6'h24, 16'hAA); wr_reg(6'h24, 16'h55); wr_reg(6'h24, 16'hC3);
    add_cyc(1, 16'h12FE, 8'hAA, 0, 0, 4'h0);
    add_cyc(1, 16'h12FF, 8'h55, 2, 0, 4'h0);
    add_cyc(1, 16'h1300, 8'hC3, 0, 0, 4'h0);
    go_wait();
    rd_reg(6'h04, rv); chk("R8 stat ok", rv, 32'h3);
    rd_reg(6'h08, rv); chk("R9 evt set", rv, 32'h2);
    wr_reg(6'h08, 16'h0);
    rd_reg(6'h08, rv); chk("R9 write0 keeps", rv, 32'h2);
    wr_reg(6'h08, 16'h2);
    rd_reg(6'h08, rv); chk("R9 w1c", rv, 32'h0);

    // R4/R5: read burst, same port
    setup(8'd4, 16'h8, 16'h0060);
    add_cyc(0, 16'h0060, 8'h11, 0, 0, 4'h0);
    add_cyc(0, 16'h0060, 8'h22, 1, 0, 4'h0);
    add_cyc(0, 16'h0060, 8'h33, 0, 0, 4'h0);
    add_cyc(0, 16'h0060, 8'h44, 0, 0, 4'h0);
    go_wait();
    rd_reg(6'h04, rv); chk("R8 read ok", rv, 32'h3);
    rd_reg(6'h28, rv); chk("R4 byte0", rv, 32'h11);
    rd_reg(6'h28, rv); chk("R4 byte1", rv, 32'h22);
    rd_reg(6'h28, rv); chk("R4 byte2", rv, 32'h33);
    rd_reg(6'h28, rv); chk("R4 byte3", rv, 32'h44);
    rd_reg(6'h28, rv); chk("R4 empty", rv, 32'h0);

    // R6 upper bound + R10 writes during burst
    setup(8'd1, 16'h0, 16'h0300);
    add_cyc(0, 16'h0300, 8'h5A, 256, 0, 4'h0);
    wr_reg(6'h00, 16'h1);
    armed = 1'b1;
    repeat (20) @(negedge clk);
    rd_reg(6'h04, rv); chk("R8 busy clears idle", rv, 32'h0);
    wr_reg(6'h20, 16'hBEEF);
    wr_reg(6'h10, 16'd5);
    wr_reg(6'h14, 16'h9);
    wr_reg(6'h24, 16'h99);
    wr_reg(6'h00, 16'h1);
    wait (armed == 1'b0);
    @(negedge clk);
    rd_reg(6'h04, rv); chk("R6 256 waits ok", rv, 32'h3);
    rd_reg(6'h20, rv); chk("R10 port kept", rv, 32'h0300);
    rd_reg(6'h10, rv); chk("R10 cnt kept", rv, 32'h1);
    rd_reg(6'h14, rv); chk("R10 mode kept", rv, 32'h0);
    rd_reg(6'h28, rv); chk("R6 data", rv, 32'h5A);
    rd_reg(6'h28, rv); chk("R10 single burst", rv, 32'h0);

    // R10: ignored wbyte push -> a write burst sends 0x00
    setup(8'd1, 16'h1, 16'h0301);
    add_cyc(1, 16'h0301, 8'h00, 0, 0, 4'h0);
    go_wait();

    // R6: 257th wait aborts
    setup(8'd2, 16'h0, 16'h0400);
    add_cyc(0, 16'h0400, 8'h00, 256, 0, 4'h6);
    go_wait();
    rd_reg(6'h04, rv); chk("R6 abort stat", rv, 32'h1);
    rd_reg(6'h28, rv); chk("R6 no data", rv, 32'h0);

    // R7: error sync on second of three, then flush (R11)
    setup(8'd3, 16'h1, 16'h0500);
    wr_reg(6'h24, 16'h01); wr_reg(6'h24, 16'h02); wr_reg(6'h24, 16'h03);
    add_cyc(1, 16'h0500, 8'h01, 0, 0, 4'h0);
    add_cyc(1, 16'h0501, 8'h02, 0, 0, 4'hA);
    go_wait();
    rd_reg(6'h04, rv); chk("R7 err stat", rv, 32'h1);
    rd_reg(6'h08, rv); chk("R9 evt on abort", rv, 32'h2);
    setup(8'd1, 16'h9, 16'h0600);
    add_cyc(1, 16'h0600, 8'h00, 0, 0, 4'h0);
    go_wait();
    rd_reg(6'h04, rv); chk("R11 flushed ok", rv, 32'h3);

    // R7: no valid sync in three clocks
    setup(8'd1, 16'h0, 16'h0700);
    add_cyc(0, 16'h0700, 8'h00, 0, 2, 4'hf);
    go_wait();
    rd_reg(6'h04, rv); chk("R7 nosync stat", rv, 32'h1);

    // R11: depth 16, 17th push dropped
    setup(8'd16, 16'h9, 16'h0080);
    for (int i = 0; i < 17; i++) wr_reg(6'h24, 16'(i + 8'h40));
    for (int i = 0; i < 16; i++) add_cyc(1, 16'h0080, 8'(i + 8'h40), 0, 0, 4'h0);
    go_wait();
    rd_reg(6'h04, rv); chk("R11 16 writes ok", rv, 32'h3);
    setup(8'd1, 16'h1, 16'h0081);
    add_cyc(1, 16'h0081, 8'h00, 0, 0, 4'h0);
    go_wait();

    // R11: start clears read FIFO
    setup(8'd2, 16'h0, 16'h0900);
    add_cyc(0, 16'h0900, 8'hE1, 0, 0, 4'h0);
    add_cyc(0, 16'h0901, 8'hE2, 0, 0, 4'h0);
    go_wait();
    setup(8'd1, 16'h0, 16'h0910);
    add_cyc(0, 16'h0910, 8'h77, 0, 0, 4'h0);
    go_wait();
    rd_reg(6'h28, rv); chk("R11 rfifo cleared", rv, 32'h77);
    rd_reg(6'h28, rv); chk("R11 rfifo empty", rv, 32'h0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule